// File: doc/BRIEF.md
# Vector Load/Store Address Sequencer

The block turns one vector memory instruction into a stream of per-element effective addresses. A one-cycle start request captures the operands: base register value, a flag marking the base field as register zero, a flag marking the base operand as scalar, a 16-bit signed displacement, the access width (word or doubleword), the vector length and an addressing mode with a shift amount. The block then issues one address per element, together with its element index, over a valid/ready stream. It pulses a done flag when the last element has been taken.

Three address patterns are offered. Unit-stride walks consecutive elements of the access width from base plus displacement. Element-stride uses the displacement itself as the stride. Bit-reversed spaces elements by displacement times width, but takes the element index with its low log2(VL) bits reversed, and shifts the scaled offset left by a power of two. This gives the butterfly reordering of a radix-2 FFT pass.

The output stream follows the usual back-pressure rule. Once `addr_valid_o` is high, the address and index stay stable until a cycle in which `addr_ready_i` is also high. The next element appears in the cycle after that handshake. The consumer may hold ready low for any number of cycles. Start requests that arrive while a sequence is in progress are dropped.

Top module: `vec_ls_agu`

## Requirements
- R1: The base term is zero when `base_zero_i` is high, and `base_i` otherwise.
- R2: Mode code 2'b00 (unit-stride), and the reserved code 2'b11, give element i the address base + sext(disp) + size*i, where size is 8 when `dword_i` is 1 and 4 when it is 0.
- R3: Mode code 2'b01 (element-stride), with `scalar_base_i` high and a non-zero displacement, gives element i the address base + sext(disp)*i.
- R4: Mode code 2'b01 with `scalar_base_i` low, or with a zero displacement, produces the unit-stride addresses of R2.
- R5: Mode code 2'b10 (bit-reversed) gives element i the address base + ((sext(disp)*size*rev(i)) << `shift_i`).
- R6: rev(i) reverses the low log2(VL) bits of i, so for VL=4 the indices 0,1,2,3 become 0,2,1,3.
- R7: Elements are issued in ascending order 0 to VL-1 for any VL from 1 to MAX_VL, with `idx_o` carrying the index and the first element valid in the cycle after start.
- R8: While `addr_valid_o` is high and `addr_ready_i` is low, `addr_o` and `idx_o` hold their values.
- R9: `done_o` is high for exactly one cycle, in the cycle after the last element is accepted, and `addr_valid_o` is then low.
- R10: A start with VL=0, VL>MAX_VL, or a VL that is not a power of two in mode 2'b10 raises `err_o` for one cycle in the next cycle and produces no addresses.
- R11: A start request while a sequence is running is ignored, and the running sequence continues unchanged.
- R12: A synchronous reset drives `addr_valid_o`, `done_o` and `err_o` low and leaves the block idle.
- R13: The displacement is sign-extended to 64 bits, and all address arithmetic wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request, captured when idle |
| base_i | input | 64 | Base register value |
| base_zero_i | input | 1 | Base field names register zero: base term is 0 |
| scalar_base_i | input | 1 | Base operand is scalar (allows element-stride) |
| disp_i | input | 16 | Signed displacement |
| dword_i | input | 1 | 1: 8-byte access, 0: 4-byte access |
| vl_i | input | 7 | Vector length |
| mode_i | input | 2 | 00 unit, 01 element-stride, 10 bit-reversed, 11 unit |
| shift_i | input | 6 | Left shift for bit-reversed mode |
| addr_valid_o | output | 1 | Address stream valid |
| addr_ready_i | input | 1 | Address stream ready |
| addr_o | output | 64 | Effective address of the current element |
| idx_o | output | 7 | Index of the current element |
| done_o | output | 1 | One-cycle pulse after the last element |
| err_o | output | 1 | One-cycle pulse for a rejected start |

## Verification
The bench sweeps vector lengths of 1 to 64, including the non-power-of-two values 3, 5 and 12, across all four mode codes and both access widths, with and without stalls. It compares every issued address with a value computed in the bench. A design that reversed all index bits rather than the low log2(VL) bits would put bit-reversed elements outside the vector. A design that took element-stride without checking the scalar flag and the non-zero displacement would give every element the same address. Directed cases cover wrap-around near 2^64 with a negative displacement, an ignored second start under stall, a reset mid-sequence and each error case. A design that advanced on valid alone, or that re-captured operands on the second start, would skip elements or change the base part-way through.

// File: rtl/vagu_pkg.sv
package vagu_pkg;
  typedef enum logic [1:0] {
    AM_UNIT = 2'b00,
    AM_ELEM = 2'b01,
    AM_BREV = 2'b10,
    AM_RSVD = 2'b11
  } amode_e;
endpackage

// File: rtl/vagu_bitrev.sv
// Reverses the low 'lg' bits of an element index; upper bits become zero.
module vagu_bitrev #(
  parameter int IDX_W = 7,
  parameter int LOG_W = 3
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [LOG_W-1:0] lg,
  output logic [IDX_W-1:0] rev
);
  always_comb begin
    rev = '0;
    for (int k = 0; k < IDX_W; k++) begin
      for (int j = 0; j < IDX_W; j++) begin
        if (int'(lg) == j + k + 1) rev[k] = idx[j];
      end
    end
  end
endmodule

// File: rtl/vagu_addr_calc.sv
// Combinational effective address for one element index.
module vagu_addr_calc
  import vagu_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int IDX_W   = 7,
  parameter int LOG_W   = 3,
  parameter int SHIFT_W = 6
) (
  input  amode_e              mode,
  input  logic [ADDR_W-1:0]   base_term,
  input  logic [ADDR_W-1:0]   disp_ext,
  input  logic                dword,
  input  logic [IDX_W-1:0]    idx,
  input  logic [LOG_W-1:0]    lg,
  input  logic [SHIFT_W-1:0]  shift,
  output logic [ADDR_W-1:0]   addr
);
  logic [IDX_W-1:0]  rev;
  logic [ADDR_W-1:0] idx_ext, rev_ext, brev_off;
  logic [1:0]        sz_sh;

  vagu_bitrev #(.IDX_W(IDX_W), .LOG_W(LOG_W)) u_rev (
    .idx (idx),
    .lg  (lg),
    .rev (rev)
  );

  assign sz_sh    = dword ? 2'd3 : 2'd2;
  assign idx_ext  = ADDR_W'(idx);
  assign rev_ext  = ADDR_W'(rev);
  assign brev_off = (disp_ext * (rev_ext << sz_sh)) << shift;

  always_comb begin
    unique case (mode)
      AM_ELEM: addr = base_term + disp_ext * idx_ext;
      AM_BREV: addr = base_term + brev_off;
      default: addr = base_term + disp_ext + (idx_ext << sz_sh);
    endcase
  end
endmodule

// File: rtl/vec_ls_agu.sv
module vec_ls_agu
  import vagu_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int DISP_W  = 16,
  parameter int MAX_VL  = 64,
  parameter int SHIFT_W = 6
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start_i,
  input  logic [ADDR_W-1:0]                 base_i,
  input  logic                              base_zero_i,
  input  logic                              scalar_base_i,
  input  logic [DISP_W-1:0]                 disp_i,
  input  logic                              dword_i,
  input  logic [$clog2(MAX_VL+1)-1:0]       vl_i,
  input  logic [1:0]                        mode_i,
  input  logic [SHIFT_W-1:0]                shift_i,
  output logic                              addr_valid_o,
  input  logic                              addr_ready_i,
  output logic [ADDR_W-1:0]                 addr_o,
  output logic [$clog2(MAX_VL+1)-1:0]       idx_o,
  output logic                              done_o,
  output logic                              err_o
);
  localparam int IDX_W = $clog2(MAX_VL + 1);
  localparam int LOG_W = (IDX_W > 1) ? $clog2(IDX_W) : 1;

  // captured operands
  logic              busy_q, done_q, err_q;
  logic [IDX_W-1:0]  idx_q, last_q;
  amode_e            mode_q;
  logic [ADDR_W-1:0] base_q, disp_q;
  logic              dword_q;
  logic [LOG_W-1:0]  lg_q;
  logic [SHIFT_W-1:0] shift_q;

  // start decode
  logic              accept, fire, bad_start;
  amode_e            mode_d;
  logic [LOG_W-1:0]  lg_d;
  logic              vl_pow2;

  assign accept  = start_i && !busy_q;
  assign fire    = busy_q && addr_ready_i;
  assign vl_pow2 = ($countones(vl_i) == 1);

  always_comb begin
    lg_d = '0;
    for (int b = 0; b < IDX_W; b++) begin
      if (vl_i[b]) lg_d = LOG_W'(b);
    end
  end

  always_comb begin
    if (mode_i == 2'b01 && scalar_base_i && (disp_i != '0)) mode_d = AM_ELEM;
    else if (mode_i == 2'b10)                               mode_d = AM_BREV;
    else                                                    mode_d = AM_UNIT;
  end

  assign bad_start = (vl_i == '0) || (int'(vl_i) > MAX_VL) ||
                     (mode_d == AM_BREV && !vl_pow2);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      idx_q   <= '0;
      last_q  <= '0;
      mode_q  <= AM_UNIT;
      base_q  <= '0;
      disp_q  <= '0;
      dword_q <= 1'b0;
      lg_q    <= '0;
      shift_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        if (bad_start) begin
          err_q <= 1'b1;
        end else begin
          busy_q  <= 1'b1;
          idx_q   <= '0;
          last_q  <= vl_i - 1'b1;
          mode_q  <= mode_d;
          base_q  <= base_zero_i ? '0 : base_i;
          disp_q  <= {{(ADDR_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
          dword_q <= dword_i;
          lg_q    <= lg_d;
          shift_q <= shift_i;
        end
      end else if (fire) begin
        if (idx_q == last_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  vagu_addr_calc #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LOG_W(LOG_W), .SHIFT_W(SHIFT_W)
  ) u_calc (
    .mode      (mode_q),
    .base_term (base_q),
    .disp_ext  (disp_q),
    .dword     (dword_q),
    .idx       (idx_q),
    .lg        (lg_q),
    .shift     (shift_q),
    .addr      (addr_o)
  );

  assign addr_valid_o = busy_q;
  assign idx_o        = idx_q;
  assign done_o       = done_q;
  assign err_o        = err_q;

  // stalled output holds (R8)
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (addr_valid_o && !addr_ready_i) |=>
      (addr_valid_o && $stable(addr_o) && $stable(idx_o)));

  // after a handshake either the next index follows or the run ends (R7)
  assert_step_R7: assert property (@(posedge clk) disable iff (rst)
    (addr_valid_o && addr_ready_i) |=>
      (done_o || (addr_valid_o && (int'(idx_o) == int'($past(idx_o)) + 1))));

  // done lasts one cycle with no address alongside it (R9)
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !addr_valid_o);

  // a rejected start yields no stream (R10)
  assert_err_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!addr_valid_o && !done_o));

  // a start while running leaves the index untouched (R11)
  assert_ignore_start_R11: assert property (@(posedge clk) disable iff (rst)
    (addr_valid_o && start_i && !addr_ready_i) |=> $stable(idx_o));
endmodule

// File: tb/test_vec_ls_agu.sv
module test_vec_ls_agu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [63:0] base_i = '0;
  logic        base_zero_i = 1'b0;
  logic        scalar_base_i = 1'b0;
  logic [15:0] disp_i = '0;
  logic        dword_i = 1'b0;
  logic [6:0]  vl_i = '0;
  logic [1:0]  mode_i = '0;
  logic [5:0]  shift_i = '0;
  logic        addr_valid_o;
  logic        addr_ready_i = 1'b0;
  logic [63:0] addr_o;
  logic [6:0]  idx_o;
  logic        done_o, err_o;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  vec_ls_agu i_vec_ls_agu (
    .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i),
    .base_zero_i(base_zero_i), .scalar_base_i(scalar_base_i),
    .disp_i(disp_i), .dword_i(dword_i), .vl_i(vl_i), .mode_i(mode_i),
    .shift_i(shift_i), .addr_valid_o(addr_valid_o),
    .addr_ready_i(addr_ready_i), .addr_o(addr_o), .idx_o(idx_o),
    .done_o(done_o), .err_o(err_o)
  );

  // operands of the current run
  logic [63:0] c_base;
  logic        c_bz, c_sc, c_dw;
  logic [15:0] c_disp;
  logic [6:0]  c_vl;
  logic [1:0]  c_mode;
  logic [5:0]  c_sh;
  string       c_tag = "";

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_addr(input int i);
    logic [63:0] bt, d, sz, r;
    int lg;
    bt = c_bz ? 64'd0 : c_base;
    d  = {{48{c_disp[15]}}, c_disp};
    sz = c_dw ? 64'd8 : 64'd4;
    if (c_mode == 2'b01 && c_sc && c_disp != 16'd0) begin
      return bt + d * 64'(i);
    end else if (c_mode == 2'b10) begin
      lg = 0;
      while ((1 << lg) < int'(c_vl)) lg++;
      r = '0;
      for (int k = 0; k < lg; k++) r = (r << 1) | 64'((i >> k) & 1);
      return bt + ((d * sz * r) << c_sh);
    end else begin
      return bt + d + sz * 64'(i);
    end
  endfunction

  function automatic string addr_tag();
    if (c_tag != "") return c_tag;
    if (c_bz) return "R1";
    if (c_mode == 2'b01) return (c_sc && c_disp != 16'd0) ? "R3" : "R4";
    if (c_mode == 2'b10) return (c_vl == 7'd4) ? "R6" : "R5";
    return "R2";
  endfunction

  function automatic bit exp_err();
    return (c_vl == 7'd0) || (c_vl > 7'd64) ||
           (c_mode == 2'b10 && $countones(c_vl) != 1);
  endfunction

  task automatic drive_ops(input logic [63:0] base);
    base_i = base; base_zero_i = c_bz; scalar_base_i = c_sc;
    disp_i = c_disp; dword_i = c_dw; vl_i = c_vl; mode_i = c_mode; shift_i = c_sh;
  endtask

  task automatic run(input bit stall, input bit poke);
    int n, cyc;
    bit rdy, held;
    @(negedge clk);
    drive_ops(c_base);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (exp_err()) begin
      check("R10 err raised", 64'(err_o), 64'd1);
      check("R10 no valid", 64'(addr_valid_o), 64'd0);
      @(negedge clk);
      check("R10 err one cycle", 64'(err_o), 64'd0);
      check("R10 still idle", 64'(addr_valid_o), 64'd0);
      return;
    end
    n = 0; cyc = 0; held = 1'b0;
    while (n < int'(c_vl) && cyc < 3000) begin
      check(held ? "R8 valid" : "R7 valid", 64'(addr_valid_o), 64'd1);
      check(held ? "R8 index" : "R7 index", 64'(idx_o), 64'(n));
      check(held ? "R8 addr" : addr_tag(), addr_o, exp_addr(n));
      if (poke && cyc == 0) begin
        addr_ready_i = 1'b0;
        drive_ops(~c_base);
        vl_i = 7'd2;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        drive_ops(c_base);
        check("R11 index kept", 64'(idx_o), 64'(n));
        check("R11 addr kept", addr_o, exp_addr(n));
      end
      rdy = stall ? ((cyc % 3) != 1) : 1'b1;
      addr_ready_i = rdy;
      @(negedge clk);
      held = !rdy;
      if (rdy) n++;
      cyc++;
    end
    addr_ready_i = 1'b0;
    check("R9 done high", 64'(done_o), 64'd1);
    check("R9 valid low", 64'(addr_valid_o), 64'd0);
    @(negedge clk);
    check("R9 done one cycle", 64'(done_o), 64'd0);
  endtask

  initial begin
    #1_500_000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int vls[9] = '{1, 2, 3, 4, 5, 8, 12, 16, 64};
    int seed;
    repeat (3) @(negedge clk);
    check("R12 valid in reset", 64'(addr_valid_o), 64'd0);
    check("R12 done in reset", 64'(done_o), 64'd0);
    check("R12 err in reset", 64'(err_o), 64'd0);
    rst = 1'b0;

    // element stride, stride 24 from 0x10
    c_base = 64'h10; c_bz = 0; c_sc = 1; c_disp = 16'd24; c_dw = 0;
    c_vl = 7'd2; c_mode = 2'b01; c_sh = 0; c_tag = "R3";
    run(0, 0);
    // unit stride, words from 0x18
    c_disp = 16'd8; c_mode = 2'b00; c_tag = "R2";
    run(0, 0);
    // bit-reversed VL=4 gives 0,2,1,3 ordering
    c_disp = 16'd4; c_mode = 2'b10; c_vl = 7'd4; c_tag = "R6";
    run(1, 0);
    // bit-reversed with shift
    c_vl = 7'd8; c_sh = 6'd2; c_dw = 1; c_tag = "R5";
    run(0, 0);
    // base field zero
    c_bz = 1; c_mode = 2'b00; c_sh = 0; c_tag = "R1";
    run(0, 0);
    // element stride requested, displacement zero: falls back
    c_bz = 0; c_mode = 2'b01; c_disp = 16'd0; c_tag = "R4";
    run(0, 0);
    // wrap with negative displacement
    c_base = 64'hFFFF_FFFF_FFFF_FFF0; c_disp = 16'hFFF8; c_mode = 2'b00;
    c_vl = 7'd6; c_tag = "R13";
    run(0, 0);
    c_mode = 2'b01; c_disp = 16'h8000;
    run(1, 0);
    // start while busy is dropped
    c_base = 64'h1000; c_disp = 16'd12; c_mode = 2'b00; c_vl = 7'd4; c_tag = "R2";
    run(0, 1);
    // rejected starts
    c_tag = ""; c_mode = 2'b10; c_vl = 7'd12;
    run(0, 0);
    c_mode = 2'b00; c_vl = 7'd0;
    run(0, 0);
    c_mode = 2'b01; c_vl = 7'd65;
    run(0, 0);

    // reset mid-sequence
    c_mode = 2'b00; c_vl = 7'd8;
    @(negedge clk);
    drive_ops(c_base);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    addr_ready_i = 1'b1;
    repeat (2) @(negedge clk);
    addr_ready_i = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R12 valid after reset", 64'(addr_valid_o), 64'd0);
    check("R12 done after reset", 64'(done_o), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R12 stays idle", 64'(addr_valid_o), 64'd0);

    // sweep
    seed = 7;
    for (int v = 0; v < 9; v++) begin
      for (int m = 0; m < 4; m++) begin
        for (int w = 0; w < 2; w++) begin
          for (int s = 0; s < 2; s++) begin
            seed = seed * 1103515245 + 12345;
            c_base = {32'(seed), 32'(seed ^ 32'h5a5a_1234)};
            c_bz   = ((seed >> 3) & 7) == 0;
            c_sc   = ((seed >> 7) & 3) != 0;
            c_disp = 16'(seed >> 11);
            c_dw   = w[0];
            c_vl   = 7'(vls[v]);
            c_mode = 2'(m);
            c_sh   = 6'((seed >> 20) & 3);
            c_tag  = "";
            run(s[0], 0);
          end
        end
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule